// File: doc/BRIEF.md
# Exception Entry and Return Unit

This unit sequences the control-flow side of exceptions for a 32-bit in-order core with a branch delay slot. The pipeline hands it an exception request carrying a vector number, the address of the faulting instruction, a flag telling whether that instruction sat in a delay slot, and the live status register. On acceptance, the unit does four things. It works out the address to resume at, which depends on the exception class and on the delay slot. It keeps a copy of the status register. It returns an updated status word with the delay-slot indicator set. It issues a redirect to the handler.

A separate return strobe reverses the entry. It hands back the saved status with the fixed-one bit forced and redirects to the saved return address. A debug trap does not vector: it only pulses a halt output. A vector number the unit does not recognise pulses an error output and changes nothing.

The request side is a valid/ready stream. `req_ready` is low only while reset is asserted. Every accepted request completes in one cycle, so the unit never applies back-pressure after reset. A request is accepted on any rising clock edge where `req_valid` and `req_ready` are both high. The return strobe and all outputs are plain control pins. Every output pulse appears in the cycle after the edge that accepted its cause.

Top module: `exc_unit`

## Requirements
- R1: While reset is asserted `req_ready` is low. After reset it is high, every output pulse is low, and the saved return address, saved status and fault address registers read zero.
- R2: An entry redirect is a single-cycle `redir_valid` pulse in the cycle after acceptance. Its target is the vector number shifted left by 8, plus 0xF0000000 when bit 14 of `sr_cur` is set and plus 0 otherwise.
- R3: For vectors 0xC (system call) and 0xD (floating point), the saved return address becomes `req_pc`+4, or `req_pc` when `req_dslot` is high.
- R4: For vectors 0x2 (bus error), 0x6 (alignment), 0x7 (illegal instruction) and 0xB (range), the saved return address becomes `req_pc`, or `req_pc`-4 when `req_dslot` is high.
- R5: Vector 0x1 (reset) redirects to its handler and leaves the saved return address unchanged.
- R6: On every vectoring entry, the saved status takes `sr_cur`. `sr_wr_valid` then pulses with `sr_wr_data` equal to `sr_cur` with bit 13 replaced by `req_dslot`.
- R7: Vector 0x7 loads `req_pc` into the fault address register. No other vector changes that register.
- R8: Vector 0xE (trap) pulses `dbg_halt` for one cycle. It gives no redirect and no status write, and leaves all three saved registers unchanged.
- R9: Any other vector number pulses `vec_err` for one cycle. It gives no redirect and no status write, and leaves all three saved registers unchanged.
- R10: A return strobe pulses `sr_wr_valid` with the saved status OR 0x8000 (bit 15 forced to one). In the same cycle it redirects to the saved return address.
- R11: `clr_next_dslot` pulses together with every entry or return redirect, and never with a halt or an error.
- R12: When a request is accepted in the same cycle as a return strobe, the exception is taken and the return strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Exception request present |
| req_ready | output | 1 | Request can be accepted (low only in reset) |
| req_vec | input | 5 | Exception vector number |
| req_pc | input | 32 | Address of the faulting instruction |
| req_dslot | input | 1 | Faulting instruction sat in a delay slot |
| sr_cur | input | 32 | Live status register |
| rfe_valid | input | 1 | Return-from-exception strobe |
| redir_valid | output | 1 | One-cycle redirect pulse |
| redir_pc | output | 32 | Redirect target (zero when no pulse) |
| sr_wr_valid | output | 1 | Status register write pulse |
| sr_wr_data | output | 32 | New status register value (zero when no pulse) |
| clr_next_dslot | output | 1 | Clear pending next-delay-slot state |
| dbg_halt | output | 1 | Debug trap halt pulse |
| vec_err | output | 1 | Unsupported vector pulse |
| epc_q | output | 32 | Saved return address |
| esr_q | output | 32 | Saved status register |
| eear_q | output | 32 | Fault address of the last illegal instruction |

## Verification
Corrupt saved state stays hidden until a later return uses it. A wrong return address or status copy shows first on the saved-register outputs in the cycle after the entry. It then shows on `redir_pc` and `sr_wr_data` in the cycle after the next return strobe. A misclassified vector shows at once as a wrong target, a missing pulse, or a spurious halt or error. Every cycle is compared against a model that carries its own copy of the three saved registers, so a wrong value is caught in the cycle it appears rather than at the end.

// File: rtl/exc_pkg.sv
package exc_pkg;
  // Vector numbers; the handler offset is derived from them.
  localparam int VEC_RESET   = 'h1;
  localparam int VEC_BUS     = 'h2;
  localparam int VEC_ALIGN   = 'h6;
  localparam int VEC_ILLEGAL = 'h7;
  localparam int VEC_RANGE   = 'hB;
  localparam int VEC_SYSCALL = 'hC;
  localparam int VEC_FLOAT   = 'hD;
  localparam int VEC_TRAP    = 'hE;

  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,  // unsupported number
    CLS_BOOT  = 3'd1,  // vectors, no return address
    CLS_AFTER = 3'd2,  // resume after the instruction
    CLS_AT    = 3'd3,  // re-execute the instruction
    CLS_TRAP  = 3'd4   // debug halt, no vectoring
  } exc_class_e;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_pkg::*;
#(
  parameter int VEC_W = 5
) (
  input  logic [VEC_W-1:0] vec,
  output exc_class_e       cls,
  output logic             is_illegal
);
  always_comb begin
    cls        = CLS_NONE;
    is_illegal = 1'b0;
    case (int'(vec))
      VEC_RESET:              cls = CLS_BOOT;
      VEC_SYSCALL, VEC_FLOAT: cls = CLS_AFTER;
      VEC_BUS, VEC_ALIGN, VEC_RANGE: cls = CLS_AT;
      VEC_ILLEGAL: begin
        cls        = CLS_AT;
        is_illegal = 1'b1;
      end
      VEC_TRAP:               cls = CLS_TRAP;
      default:                cls = CLS_NONE;
    endcase
  end
endmodule

// File: rtl/exc_addr_calc.sv
module exc_addr_calc
  import exc_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              VEC_W      = 5,
  parameter int              VEC_SHIFT  = 8,
  parameter int              INSN_BYTES = 4,
  parameter logic [XLEN-1:0] HIGH_BASE  = 32'hF000_0000
) (
  input  logic [XLEN-1:0]  pc,
  input  logic             dslot,
  input  exc_class_e       cls,
  input  logic [VEC_W-1:0] vec,
  input  logic             high_sel,
  output logic [XLEN-1:0]  ret_addr,
  output logic [XLEN-1:0]  handler
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] vec_ext;
  logic [XLEN-1:0] base;

  assign vec_ext = XLEN'(vec);
  assign base    = high_sel ? HIGH_BASE : '0;
  assign handler = (vec_ext << VEC_SHIFT) + base;

  always_comb begin
    ret_addr = pc;
    if (cls == CLS_AFTER)
      ret_addr = dslot ? pc : pc + STEP;
    else if (cls == CLS_AT)
      ret_addr = dslot ? pc - STEP : pc;
  end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs #(
  parameter int XLEN  = 32,
  parameter int NREGS = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NREGS-1:0]           we,
  input  logic [NREGS-1:0][XLEN-1:0] wdata,
  output logic [NREGS-1:0][XLEN-1:0] q
);
  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[g] <= '0;
      else if (we[g]) q[g] <= wdata[g];
    end
  end
endmodule

// File: rtl/exc_unit.sv
module exc_unit
  import exc_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter int              VEC_W       = 5,
  parameter int              VEC_SHIFT   = 8,
  parameter int              INSN_BYTES  = 4,
  parameter logic [XLEN-1:0] HIGH_BASE   = 32'hF000_0000,
  parameter int              DSX_BIT     = 13,
  parameter int              HIGHVEC_BIT = 14,
  parameter int              FO_BIT      = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VEC_W-1:0] req_vec,
  input  logic [XLEN-1:0]  req_pc,
  input  logic             req_dslot,
  input  logic [XLEN-1:0]  sr_cur,
  input  logic             rfe_valid,
  output logic             redir_valid,
  output logic [XLEN-1:0]  redir_pc,
  output logic             sr_wr_valid,
  output logic [XLEN-1:0]  sr_wr_data,
  output logic             clr_next_dslot,
  output logic             dbg_halt,
  output logic             vec_err,
  output logic [XLEN-1:0]  epc_q,
  output logic [XLEN-1:0]  esr_q,
  output logic [XLEN-1:0]  eear_q
);
  localparam int IDX_EPC  = 0;
  localparam int IDX_ESR  = 1;
  localparam int IDX_EEAR = 2;
  localparam int NREGS    = 3;
  localparam logic [XLEN-1:0] FO_MASK = XLEN'(1) << FO_BIT;

  exc_class_e      cls;
  logic            is_illegal;
  logic [XLEN-1:0] ret_addr;
  logic [XLEN-1:0] handler;

  logic take_exc, take_rfe, entry, trap, bad;
  logic [NREGS-1:0]           st_we;
  logic [NREGS-1:0][XLEN-1:0] st_wd;
  logic [NREGS-1:0][XLEN-1:0] st_q;
  logic [XLEN-1:0]            sr_entry;

  assign req_ready = rst_n;

  exc_classify #(.VEC_W(VEC_W)) u_classify (
    .vec        (req_vec),
    .cls        (cls),
    .is_illegal (is_illegal)
  );

  exc_addr_calc #(
    .XLEN(XLEN), .VEC_W(VEC_W), .VEC_SHIFT(VEC_SHIFT),
    .INSN_BYTES(INSN_BYTES), .HIGH_BASE(HIGH_BASE)
  ) u_addr (
    .pc       (req_pc),
    .dslot    (req_dslot),
    .cls      (cls),
    .vec      (req_vec),
    .high_sel (sr_cur[HIGHVEC_BIT]),
    .ret_addr (ret_addr),
    .handler  (handler)
  );

  assign take_exc = req_valid && req_ready;
  assign take_rfe = rfe_valid && rst_n && !take_exc;
  assign entry    = take_exc && (cls == CLS_BOOT || cls == CLS_AFTER || cls == CLS_AT);
  assign trap     = take_exc && (cls == CLS_TRAP);
  assign bad      = take_exc && (cls == CLS_NONE);

  always_comb begin
    sr_entry          = sr_cur;
    sr_entry[DSX_BIT] = req_dslot;
  end

  always_comb begin
    st_we           = '0;
    st_we[IDX_EPC]  = take_exc && (cls == CLS_AFTER || cls == CLS_AT);
    st_we[IDX_ESR]  = entry;
    st_we[IDX_EEAR] = take_exc && is_illegal;
    st_wd           = '0;
    st_wd[IDX_EPC]  = ret_addr;
    st_wd[IDX_ESR]  = sr_cur;
    st_wd[IDX_EEAR] = req_pc;
  end

  exc_state_regs #(.XLEN(XLEN), .NREGS(NREGS)) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (st_we),
    .wdata (st_wd),
    .q     (st_q)
  );

  assign epc_q  = st_q[IDX_EPC];
  assign esr_q  = st_q[IDX_ESR];
  assign eear_q = st_q[IDX_EEAR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_valid    <= 1'b0;
      redir_pc       <= '0;
      sr_wr_valid    <= 1'b0;
      sr_wr_data     <= '0;
      clr_next_dslot <= 1'b0;
      dbg_halt       <= 1'b0;
      vec_err        <= 1'b0;
    end else begin
      redir_valid    <= entry || take_rfe;
      sr_wr_valid    <= entry || take_rfe;
      clr_next_dslot <= entry || take_rfe;
      dbg_halt       <= trap;
      vec_err        <= bad;
      if (entry) begin
        redir_pc   <= handler;
        sr_wr_data <= sr_entry;
      end else if (take_rfe) begin
        redir_pc   <= st_q[IDX_EPC];
        sr_wr_data <= st_q[IDX_ESR] | FO_MASK;
      end else begin
        redir_pc   <= '0;
        sr_wr_data <= '0;
      end
    end
  end
endmodule

// File: rtl/exc_unit_chk.sv
module exc_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            redir_valid,
  input logic            sr_wr_valid,
  input logic            clr_next_dslot,
  input logic            dbg_halt,
  input logic            vec_err,
  input logic [XLEN-1:0] epc_q,
  input logic [XLEN-1:0] esr_q,
  input logic [XLEN-1:0] eear_q
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({redir_valid, dbg_halt, vec_err})); // R8

  AST_TRAP_NO_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_halt |-> ($stable(epc_q) && $stable(esr_q) && $stable(eear_q) && !sr_wr_valid)); // R8

  AST_ERR_NO_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_err |-> ($stable(epc_q) && $stable(esr_q) && $stable(eear_q) && !sr_wr_valid)); // R9

  AST_CLEAR_WITH_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid == clr_next_dslot); // R11

  AST_SR_WITH_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_valid |-> redir_valid); // R10
endmodule

bind exc_unit exc_unit_chk #(.XLEN(XLEN)) u_exc_unit_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .redir_valid    (redir_valid),
  .sr_wr_valid    (sr_wr_valid),
  .clr_next_dslot (clr_next_dslot),
  .dbg_halt       (dbg_halt),
  .vec_err        (vec_err),
  .epc_q          (epc_q),
  .esr_q          (esr_q),
  .eear_q         (eear_q)
);

// File: tb/exc_unit_bench.sv
module exc_unit_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        rv;
    logic [31:0] rpc;
    logic        sv;
    logic [31:0] sdata;
    logic        clr;
    logic        halt;
    logic        err;
    logic [31:0] epc;
    logic [31:0] esr;
    logic [31:0] eear;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [4:0]  req_vec = '0;
  logic [31:0] req_pc = '0;
  logic        req_dslot = 1'b0;
  logic [31:0] sr_cur = '0;
  logic        rfe_valid = 1'b0;
  logic        redir_valid, sr_wr_valid, clr_next_dslot, dbg_halt, vec_err;
  logic [31:0] redir_pc, sr_wr_data, epc_q, esr_q, eear_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  exp_t  exp_q[$];
  string tag_q[$];

  logic [31:0] m_epc = '0, m_esr = '0, m_eear = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_unit u_exc_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vec(req_vec), .req_pc(req_pc), .req_dslot(req_dslot), .sr_cur(sr_cur),
    .rfe_valid(rfe_valid), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .sr_wr_valid(sr_wr_valid), .sr_wr_data(sr_wr_data),
    .clr_next_dslot(clr_next_dslot), .dbg_halt(dbg_halt), .vec_err(vec_err),
    .epc_q(epc_q), .esr_q(esr_q), .eear_q(eear_q)
  );

  function automatic exp_t idle_exp();
    exp_t e;
    e = '0;
    e.epc = m_epc; e.esr = m_esr; e.eear = m_eear;
    return e;
  endfunction

  // Driver: one operation per cycle, expectation pushed before the edge.
  task automatic do_exc(input logic [4:0] v, input logic [31:0] pc, input logic ds,
                        input logic [31:0] sr, input logic rfe, input string tag);
    exp_t e;
    logic [31:0] h;
    @(negedge clk);
    req_valid = 1'b1; req_vec = v; req_pc = pc; req_dslot = ds; sr_cur = sr;
    rfe_valid = rfe;
    h = {19'd0, v, 8'd0} + (sr[14] ? 32'hF000_0000 : 32'h0);
    case (v)
      5'h1, 5'h2, 5'h6, 5'h7, 5'hB, 5'hC, 5'hD: begin
        if (v == 5'hC || v == 5'hD) m_epc = ds ? pc : pc + 32'd4;
        else if (v != 5'h1)         m_epc = ds ? pc - 32'd4 : pc;
        if (v == 5'h7) m_eear = pc;
        m_esr = sr;
        e = idle_exp();
        e.rv = 1'b1; e.rpc = h; e.sv = 1'b1; e.clr = 1'b1;
        e.sdata = {sr[31:14], ds, sr[12:0]};
      end
      5'hE: begin e = idle_exp(); e.halt = 1'b1; end
      default: begin e = idle_exp(); e.err = 1'b1; end
    endcase
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic do_rfe(input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b0; rfe_valid = 1'b1;
    e = idle_exp();
    e.rv = 1'b1; e.rpc = m_epc; e.sv = 1'b1; e.clr = 1'b1;
    e.sdata = m_esr | 32'h0000_8000;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic do_idle(input string tag);
    @(negedge clk);
    req_valid = 1'b0; rfe_valid = 1'b0;
    exp_q.push_back(idle_exp());
    tag_q.push_back(tag);
  endtask

  // Monitor: compares the registered outputs just after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {redir_valid, redir_pc, sr_wr_valid, sr_wr_data, clr_next_dslot,
             dbg_halt, vec_err, epc_q, esr_q, eear_q};
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s: got rv=%0b rpc=%h sv=%0b sr=%h clr=%0b halt=%0b err=%0b epc=%h esr=%h eear=%h expected rv=%0b rpc=%h sv=%0b sr=%h clr=%0b halt=%0b err=%0b epc=%h esr=%h eear=%h",
                   t, a.rv, a.rpc, a.sv, a.sdata, a.clr, a.halt, a.err, a.epc, a.esr, a.eear,
                   e.rv, e.rpc, e.sv, e.sdata, e.clr, e.halt, e.err, e.epc, e.esr, e.eear);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (req_ready !== 1'b0) begin
      fails++;
      $display("FAIL R1 ready in reset: got %0b expected 0", req_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (req_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 ready after reset: got %0b expected 1", req_ready);
    end
    do_idle("R1 reset state");
    do_exc(5'hC, 32'h0000_1000, 1'b0, 32'h0000_8001, 1'b0, "R3 R2 R6 syscall low base");
    do_exc(5'hC, 32'h0000_2000, 1'b1, 32'h0000_4003, 1'b0, "R3 R2 R6 syscall delay slot high base");
    do_exc(5'hD, 32'h0000_3008, 1'b0, 32'h0000_2000, 1'b0, "R3 float clears delay bit");
    do_exc(5'h2, 32'h0000_4000, 1'b1, 32'h0000_0001, 1'b0, "R4 bus error delay slot");
    do_exc(5'h6, 32'h0000_5004, 1'b0, 32'h0000_0005, 1'b0, "R4 alignment");
    do_exc(5'h7, 32'h0000_6000, 1'b1, 32'h0000_0007, 1'b0, "R7 R4 illegal latches address");
    do_idle("R2 redirect is a single pulse");
    do_exc(5'hB, 32'h0000_7000, 1'b0, 32'h0000_4009, 1'b0, "R7 range keeps fault address");
    do_exc(5'h1, 32'h9999_0000, 1'b1, 32'h0000_0011, 1'b0, "R5 reset keeps return address");
    do_rfe("R10 R11 return after reset entry");
    do_exc(5'hE, 32'h0000_8000, 1'b0, 32'h1234_5678, 1'b0, "R8 trap halts only");
    do_rfe("R8 trap left saved registers for return");
    do_exc(5'h3, 32'h0000_8100, 1'b1, 32'hFFFF_FFFF, 1'b0, "R9 unsupported 0x3");
    do_exc(5'h1F, 32'h0000_8200, 1'b0, 32'h0000_0000, 1'b0, "R9 unsupported 0x1F");
    do_rfe("R9 error left saved registers for return");
    do_exc(5'hD, 32'h0000_A000, 1'b1, 32'h0000_00A0, 1'b1, "R12 exception wins over return");
    do_exc(5'hE, 32'h0000_B000, 1'b0, 32'h0000_00B0, 1'b1, "R12 trap wins over return");
    do_rfe("R10 back-to-back return");
    do_idle("R11 quiet after return");
    while (exp_q.size() != 0) @(posedge clk);
    #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule